// File: doc/BRIEF.md
# Packed Program Counter and Status Register

This unit holds, in one 32-bit word, the fetch pointer and the processor status of a core whose address space is 26 bits wide. The pointer counts 32-bit words. It sits in bits [25:2], so the byte address it gives always has its two low bits clear. The upper six bits carry the four condition flags and two interrupt disable bits. The lowest two bits carry the processor mode.

Each clock edge the control port can do several things. It can step the pointer forward by one word or apply a signed word offset for a branch. A branch may also save the whole packed word as a return link, so the caller's status travels with its return address. The port can also load the ALU's condition flags, or replace the word outright. In User mode an outright write cannot touch the interrupt or mode bits. A separate combinational check flags any data access request whose byte address is 2^26 or higher.

Top module: `pc_psr_unit`

## Requirements
- R1: After reset `word_o` is 32'h0C00_0003: PC=0, N=Z=C=V=0, I (bit 27)=1, F (bit 26)=1, mode Supervisor. Modes are User=2'b00, FIQ=2'b01, IRQ=2'b10, Supervisor=2'b11 in bits [1:0]. `link_vld_o` is 0.
- R2: With `inc_i` high and no branch or full write, the PC field (bits [25:2]) rises by one on the edge and wraps from 24'hFFFFFF to 0. The status bits are unchanged.
- R3: With `br_i` high and no full write, the PC field becomes the old PC plus the sign-extended 24-bit `br_off_i`, modulo 2^24, wrapping either way. A branch takes precedence over `inc_i`.
- R4: A branch with `link_i` high loads `link_o` with the whole packed word as it stood before the edge. It raises `link_vld_o` for exactly the following cycle. A branch without `link_i` leaves `link_vld_o` low.
- R5: `flag_we_i` loads `flags_i` into bits [31:28] (N,Z,C,V from MSB) on the same edge as any PC update. No other bit is affected.
- R6: In a privileged mode (mode not 2'b00), `full_we_i` loads `full_wdata_i` into the whole word. It overrides branch, link, increment and flag write in that cycle.
- R7: In User mode, `full_we_i` updates only the PC field and bits [31:28]. Bits [27:26] and [1:0] keep their values.
- R8: `dacc_exc_o` is high in the same cycle that `dacc_req_i` is high with `dacc_addr_i` >= 2^26. It is low otherwise, including at address 26'h3FF_FFFF.
- R9: `fetch_addr_o` equals the PC field shifted left by two, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Step PC by one word |
| br_i | input | 1 | Apply branch offset |
| link_i | input | 1 | Save packed word on branch |
| br_off_i | input | 24 | Signed word offset |
| flag_we_i | input | 1 | Load condition flags |
| flags_i | input | 4 | N,Z,C,V from the ALU |
| full_we_i | input | 1 | Replace the packed word |
| full_wdata_i | input | 32 | Data for the full write |
| dacc_req_i | input | 1 | Data access request |
| dacc_addr_i | input | 32 | Data access byte address |
| word_o | output | 32 | Packed PC and status |
| fetch_addr_o | output | 32 | Byte fetch address |
| link_o | output | 32 | Saved link word |
| link_vld_o | output | 1 | Link saved on the last edge |
| dacc_exc_o | output | 1 | Address range exception |

## Verification
A flag write and a branch can land on the same edge. This tests that the two update paths merge into one register without one clobbering the other. The bench asserts `flag_we_i` and `br_i` together and expects a single word with the new flags and the moved PC, while I, F and mode stay unchanged. A full write is also issued together with a branch, a link, an increment and a flag write. The expected result is that only the written word survives and no link is reported.

// File: rtl/pc_psr_pkg.sv
package pc_psr_pkg;
  typedef enum logic [1:0] {
    MODE_USR = 2'b00,
    MODE_FIQ = 2'b01,
    MODE_IRQ = 2'b10,
    MODE_SVC = 2'b11
  } mode_e;

  typedef struct packed {
    logic [3:0] nzcv;
    logic       irq_dis;
    logic       fiq_dis;
    mode_e      mode;
  } psr_t;

  localparam psr_t PSR_RESET = '{nzcv: 4'h0, irq_dis: 1'b1, fiq_dis: 1'b1, mode: MODE_SVC};
endpackage

// File: rtl/pc_step_calc.sv
module pc_step_calc #(
  parameter int PC_W = 24
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            inc_i,
  input  logic            br_i,
  input  logic [PC_W-1:0] br_off_i,
  input  logic            full_we_i,
  input  logic [PC_W-1:0] wr_pc_i,
  output logic [PC_W-1:0] pc_nxt_o
);
  // modulo 2^PC_W arithmetic: signed offset wraps naturally
  always_comb begin
    if (full_we_i)   pc_nxt_o = wr_pc_i;
    else if (br_i)   pc_nxt_o = pc_i + br_off_i;
    else if (inc_i)  pc_nxt_o = pc_i + PC_W'(1);
    else             pc_nxt_o = pc_i;
  end
endmodule

// File: rtl/psr_upd_calc.sv
module psr_upd_calc
  import pc_psr_pkg::*;
(
  input  psr_t       psr_i,
  input  logic       flag_we_i,
  input  logic [3:0] flags_i,
  input  logic       full_we_i,
  input  psr_t       wr_psr_i,
  output psr_t       psr_nxt_o
);
  logic priv;
  assign priv = (psr_i.mode != MODE_USR);

  always_comb begin
    psr_nxt_o = psr_i;
    if (full_we_i) begin
      psr_nxt_o.nzcv = wr_psr_i.nzcv;
      if (priv) begin
        psr_nxt_o.irq_dis = wr_psr_i.irq_dis;
        psr_nxt_o.fiq_dis = wr_psr_i.fiq_dis;
        psr_nxt_o.mode    = wr_psr_i.mode;
      end
    end else if (flag_we_i) begin
      psr_nxt_o.nzcv = flags_i;
    end
  end
endmodule

// File: rtl/dacc_range_chk.sv
module dacc_range_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 26
) (
  input  logic              req_i,
  input  logic [WORD_W-1:0] addr_i,
  output logic              exc_o
);
  generate
    if (ADDR_W < WORD_W) begin : g_chk
      assign exc_o = req_i && (|addr_i[WORD_W-1:ADDR_W]);
    end else begin : g_full
      logic unused_req;
      assign unused_req = req_i;
      assign exc_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pc_psr_unit.sv
module pc_psr_unit
  import pc_psr_pkg::*;
#(
  parameter int PC_W   = 24,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              br_i,
  input  logic              link_i,
  input  logic [PC_W-1:0]   br_off_i,
  input  logic              flag_we_i,
  input  logic [3:0]        flags_i,
  input  logic              full_we_i,
  input  logic [WORD_W-1:0] full_wdata_i,
  input  logic              dacc_req_i,
  input  logic [WORD_W-1:0] dacc_addr_i,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] fetch_addr_o,
  output logic [WORD_W-1:0] link_o,
  output logic              link_vld_o,
  output logic              dacc_exc_o
);
  localparam int ADDR_W = PC_W + 2;
  localparam int PC_LO  = 2;
  localparam int PC_HI  = PC_LO + PC_W - 1;
  localparam int FLG_LO = PC_HI + 3;

  logic [PC_W-1:0] pc_q, pc_nxt;
  psr_t            psr_q, psr_nxt, wr_psr;
  logic            link_fire;

  assign wr_psr = '{nzcv:    full_wdata_i[WORD_W-1:FLG_LO],
                    irq_dis: full_wdata_i[PC_HI+2],
                    fiq_dis: full_wdata_i[PC_HI+1],
                    mode:    mode_e'(full_wdata_i[1:0])};

  pc_step_calc #(.PC_W(PC_W)) u_pc (
    .pc_i      (pc_q),
    .inc_i     (inc_i),
    .br_i      (br_i),
    .br_off_i  (br_off_i),
    .full_we_i (full_we_i),
    .wr_pc_i   (full_wdata_i[PC_HI:PC_LO]),
    .pc_nxt_o  (pc_nxt)
  );

  psr_upd_calc u_psr (
    .psr_i     (psr_q),
    .flag_we_i (flag_we_i),
    .flags_i   (flags_i),
    .full_we_i (full_we_i),
    .wr_psr_i  (wr_psr),
    .psr_nxt_o (psr_nxt)
  );

  dacc_range_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rng (
    .req_i  (dacc_req_i),
    .addr_i (dacc_addr_i),
    .exc_o  (dacc_exc_o)
  );

  assign link_fire = br_i && link_i && !full_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      psr_q      <= PSR_RESET;
      link_o     <= '0;
      link_vld_o <= 1'b0;
    end else begin
      pc_q       <= pc_nxt;
      psr_q      <= psr_nxt;
      link_vld_o <= link_fire;
      if (link_fire) link_o <= word_o;
    end
  end

  assign word_o       = {psr_q.nzcv, psr_q.irq_dis, psr_q.fiq_dis, pc_q, psr_q.mode};
  assign fetch_addr_o = WORD_W'({pc_q, 2'b00});
endmodule

// File: rtl/pc_psr_chk.sv
module pc_psr_chk #(
  parameter int PC_W   = 24,
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inc_i,
  input logic              br_i,
  input logic              link_i,
  input logic [PC_W-1:0]   br_off_i,
  input logic              flag_we_i,
  input logic              full_we_i,
  input logic              dacc_req_i,
  input logic [WORD_W-1:0] dacc_addr_i,
  input logic [WORD_W-1:0] word_o,
  input logic [WORD_W-1:0] link_o,
  input logic              link_vld_o,
  input logic              dacc_exc_o
);
  logic [PC_W-1:0] pc;
  assign pc = word_o[PC_W+1:2];

  a_r2_inc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !br_i && !full_we_i) |=> pc == $past(pc) + PC_W'(1));

  a_r3_branch_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_i && !full_we_i) |=> pc == $past(pc) + $past(br_off_i));

  a_r4_link_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_i && link_i && !full_we_i) |=> (link_vld_o && link_o == $past(word_o)));

  a_r4_no_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(br_i && link_i) |=> !link_vld_o);

  a_r5_flag_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && !full_we_i) |=> word_o[WORD_W-5:PC_W+2] == $past(word_o[WORD_W-5:PC_W+2])
                                  && word_o[1:0] == $past(word_o[1:0]));

  a_r7_user_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_we_i && word_o[1:0] == 2'b00) |=> word_o[1:0] == 2'b00
                                           && $stable(word_o[WORD_W-5:PC_W+2]));

  a_r8_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dacc_addr_i[WORD_W-1:PC_W+2] == '0 || !dacc_req_i) |-> !dacc_exc_o);
endmodule

bind pc_psr_unit pc_psr_chk #(.PC_W(PC_W), .WORD_W(WORD_W)) u_pc_psr_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .inc_i       (inc_i),
  .br_i        (br_i),
  .link_i      (link_i),
  .br_off_i    (br_off_i),
  .flag_we_i   (flag_we_i),
  .full_we_i   (full_we_i),
  .dacc_req_i  (dacc_req_i),
  .dacc_addr_i (dacc_addr_i),
  .word_o      (word_o),
  .link_o      (link_o),
  .link_vld_o  (link_vld_o),
  .dacc_exc_o  (dacc_exc_o)
);

// File: tb/tb_pc_psr_unit.sv
module tb_pc_psr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inc_i = 0, br_i = 0, link_i = 0, flag_we_i = 0, full_we_i = 0, dacc_req_i = 0;
  logic [23:0] br_off_i = '0;
  logic [3:0]  flags_i = '0;
  logic [31:0] full_wdata_i = '0, dacc_addr_i = '0;
  logic [31:0] word_o, fetch_addr_o, link_o;
  logic        link_vld_o, dacc_exc_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pc_psr_unit dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    inc_i = 0; br_i = 0; link_i = 0; flag_we_i = 0; full_we_i = 0;
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i); idle();
  endtask

  task automatic t_reset();
    chk("R1 reset word", word_o, 32'h0C00_0003);
    chk("R1 reset link_vld", {31'b0, link_vld_o}, 0);
    chk("R9 reset fetch", fetch_addr_o, 0);
  endtask

  task automatic t_inc();
    for (int i = 0; i < 3; i++) begin inc_i = 1; step(); end
    chk("R2 inc x3", word_o, 32'h0C00_000F);
    chk("R9 fetch after inc", fetch_addr_o, 32'h0000_000C);
  endtask

  task automatic t_branch();
    br_i = 1; inc_i = 1; br_off_i = 24'h000010; step();
    chk("R3 fwd branch beats inc", word_o, 32'h0C00_004F);
    br_i = 1; br_off_i = 24'hFFFFE0; step();
    chk("R3 back wrap", word_o, 32'h0FFF_FFCF);
    chk("R9 fetch wrapped", fetch_addr_o, 32'h03FF_FFCC);
  endtask

  task automatic t_inc_wrap();
    full_we_i = 1; full_wdata_i = 32'hA3FF_FFFF; step();
    chk("R6 priv full write", word_o, 32'hA3FF_FFFF);
    inc_i = 1; step();
    chk("R2 inc wraps", word_o, 32'hA000_0003);
  endtask

  task automatic t_flag_branch();
    flag_we_i = 1; flags_i = 4'h5; br_i = 1; br_off_i = 24'h000002; step();
    chk("R5 flags with branch", word_o, 32'h5000_000B);
  endtask

  task automatic t_link();
    br_i = 1; link_i = 1; br_off_i = 24'h000100; step();
    chk("R4 link word", link_o, 32'h5000_000B);
    chk("R4 link_vld pulse", {31'b0, link_vld_o}, 1);
    chk("R3 bl target", word_o, 32'h5000_040B);
    step();
    chk("R4 link_vld drops", {31'b0, link_vld_o}, 0);
    br_i = 1; br_off_i = 24'h000001; step();
    chk("R4 plain branch no link", {31'b0, link_vld_o}, 0);
    chk("R4 link held", link_o, 32'h5000_000B);
  endtask

  task automatic t_full_prio();
    full_we_i = 1; full_wdata_i = 32'h3C00_0013;
    br_i = 1; link_i = 1; inc_i = 1; flag_we_i = 1; flags_i = 4'hF; br_off_i = 24'h5; step();
    chk("R6 full write wins", word_o, 32'h3C00_0013);
    chk("R6 no link on full write", {31'b0, link_vld_o}, 0);
  endtask

  task automatic t_user();
    full_we_i = 1; full_wdata_i = 32'h0000_0100; step();
    chk("R6 enter user", word_o, 32'h0000_0100);
    full_we_i = 1; full_wdata_i = 32'hFFFF_FFFF; step();
    chk("R7 user write masked", word_o, 32'hF3FF_FFFC);
  endtask

  task automatic t_range();
    dacc_req_i = 1; dacc_addr_i = 32'h03FF_FFFF; #1;
    chk("R8 top of range", {31'b0, dacc_exc_o}, 0);
    dacc_addr_i = 32'h0400_0000; #1;
    chk("R8 first bad addr", {31'b0, dacc_exc_o}, 1);
    dacc_addr_i = 32'hFFFF_FFFC; #1;
    chk("R8 high addr", {31'b0, dacc_exc_o}, 1);
    dacc_req_i = 0; #1;
    chk("R8 no request", {31'b0, dacc_exc_o}, 0);
  endtask

  initial begin
    #7 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_inc();
    t_branch();
    t_inc_wrap();
    t_flag_branch();
    t_link();
    t_full_prio();
    t_range();
    t_user();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (2000) @(posedge clk_i); n_cmp++; n_bad++; $display("FAIL watchdog expired"); end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule